// File: doc/BRIEF.md
# NAND Page Read Pointer Controller

This block is the read side of a small-page NAND-style memory device. Command bytes and address bytes arrive on one byte-wide input bus, each marked by its own latch strobe. The controller keeps a column pointer over a 528-byte page, which is 512 main bytes followed by 16 spare bytes. It returns one page byte for each read strobe. Page contents come from an internal synchronous array that can be inferred as block RAM.

Three read commands pick the starting region. 00h starts in the main area at the column byte. 01h starts in the upper half of the main area. 50h enters a sticky spare mode that addresses only the 16 spare bytes. Each page fetch holds a busy flag for a fixed number of cycles. When a page is finished, output carries on into the next page after another busy interval, with no new address. At the last page of a block this automatic continuation stops. A new command and address are then needed.

Top module: `nand_page_reader`

## Requirements
- R1: After synchronous reset, `busy`, `dout_vld` and `end_of_block` are low and `dout` is 0.
- R2: A read strobe accepted while streaming raises `dout_vld` on the next cycle, with the byte at (row r, column c) on `dout`, then advances the column by one. The stored byte is ((c mod 256) XOR 32*(r mod 4) XOR (c div 256)) mod 256.
- R3: Command 00h leaves spare mode, and reading starts at the column given by the column address byte.
- R4: Command 01h, outside spare mode, starts at column 256 plus the column byte. Any later page starts at column 0.
- R5: Command 50h enters spare mode. The start column is 512 plus the low nibble of the column byte, and the upper nibble is ignored. Spare mode persists through 01h commands and page changes, and only 00h clears it.
- R6: The address sequence is one column byte, then the low row byte, then the high row byte. The low four row bits select the page within a 16-page block. Address bytes arriving outside an address sequence are ignored, and so are read strobes during one.
- R7: Busy goes high on the cycle after the final address byte and stays high for exactly BUSY_CYCLES cycles. While busy, read strobes are ignored, `dout_vld` stays low and `dout` is 0.
- R8: In main modes, after column 527 is delivered, the controller goes busy and then continues at column 0 of the next row.
- R9: In spare mode, after column 527 is delivered, the controller goes busy and then continues at column 512 of the next row.
- R10: If the finished page has page field 15, no busy follows. Every later strobe returns FFh with `dout_vld` high and sets the sticky `end_of_block`.
- R11: Any command byte clears `end_of_block`. An unrecognised command ends the read and leaves the controller idle, where strobes are ignored and the region mode is unchanged.
- R12: A command strobe takes priority over an address strobe or read strobe in the same cycle. A command is accepted at any time, including while busy, and it cancels the busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Latch `bus_in` as a command byte |
| addr_we | input | 1 | Latch `bus_in` as an address byte |
| bus_in | input | 8 | Command/address byte |
| rd_stb | input | 1 | Read strobe, one byte per cycle high |
| dout | output | 8 | Registered read data, 0 when not valid |
| dout_vld | output | 1 | `dout` carries a byte this cycle |
| busy | output | 1 | Page load in progress |
| end_of_block | output | 1 | Sticky: a strobe arrived after the block end |

## Verification
The bench holds read strobes high through every busy interval and page change. A controller that accepted a strobe one cycle early or late, or that restarted a new row at the wrong column, would therefore produce a byte the model does not expect. It drives spare mode with a nonzero upper nibble and then issues 01h with spare mode still set, to catch a design that decodes the ignored bits or drops spare mode too soon. It walks the last page of a block in both main and spare mode. A design that rolled over, or whose end flag failed to stick or to clear on a new command, would diverge from the model. Commands that land together with an address byte, a read strobe or a busy interval check the priority and cancel rules.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LOAD,
    ST_STREAM,
    ST_END
  } rd_state_e;

  localparam logic [7:0] OP_MAIN  = 8'h00;
  localparam logic [7:0] OP_UPPER = 8'h01;
  localparam logic [7:0] OP_SPARE = 8'h50;

  typedef struct packed {
    logic main;
    logic upper;
    logic spare;
    logic other;
  } op_dec_t;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_rd_pkg::*;
(
  input  logic [7:0] code_i,
  output op_dec_t    dec_o
);

  always_comb begin
    dec_o       = '0;
    dec_o.main  = (code_i == OP_MAIN);
    dec_o.upper = (code_i == OP_UPPER);
    dec_o.spare = (code_i == OP_SPARE);
    dec_o.other = !(dec_o.main || dec_o.upper || dec_o.spare);
  end

endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
  parameter int ADDR_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  restart,
  input  logic                  arm,
  input  logic                  we,
  input  logic [7:0]            din,
  output logic [ADDR_CYC*8-1:0] bytes_o,
  output logic                  done
);

  localparam int CNT_W = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;
  localparam int LAST  = ADDR_CYC - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       held_q [ADDR_CYC];
  logic             take;

  assign take = arm && we;
  assign done = take && (cnt_q == CNT_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= (cnt_q == CNT_W'(LAST)) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      held_q[cnt_q] <= din;
    end
  end

  // The byte arriving this cycle is passed straight through
  for (genvar gi = 0; gi < ADDR_CYC; gi++) begin : g_view
    assign bytes_o[gi*8 +: 8] = (take && cnt_q == CNT_W'(gi)) ? din : held_q[gi];
  end

  // R6
  addr_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LAST));

endmodule

// File: rtl/nand_load_timer.sv
module nand_load_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic expire
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && (cnt_q != '0) && !abort |=> busy_q);

endmodule

// File: rtl/nand_page_rom.sv
module nand_page_rom #(
  parameter int STORED_PAGES = 4,
  parameter int PAGE_BYTES   = 528
) (
  input  logic                            clk,
  input  logic [$clog2(STORED_PAGES)-1:0] page_i,
  input  logic [$clog2(PAGE_BYTES)-1:0]   col_i,
  output logic [7:0]                      q_o
);

  localparam int DEPTH  = STORED_PAGES * PAGE_BYTES;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  initial begin
    int p;
    int c;
    for (int i = 0; i < DEPTH; i++) begin
      p = i / PAGE_BYTES;
      c = i % PAGE_BYTES;
      mem[i] = 8'((c % 256) ^ ((p % 8) * 32) ^ (c / 256));
    end
  end

  assign addr = ADDR_W'(page_i) * ADDR_W'(PAGE_BYTES) + ADDR_W'(col_i);

  always_ff @(posedge clk) begin
    q_o <= mem[addr];
  end

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int         PAGE_MAIN     = 512,
  parameter int         PAGE_SPARE    = 16,
  parameter int         PAGES_PER_BLK = 16,
  parameter int         ROW_BYTES     = 2,
  parameter int         BUSY_CYCLES   = 20,
  parameter int         STORED_PAGES  = 4,
  parameter logic [7:0] IDLE_BYTE     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic       addr_we,
  input  logic [7:0] bus_in,
  input  logic       rd_stb,
  output logic [7:0] dout,
  output logic       dout_vld,
  output logic       busy,
  output logic       end_of_block
);

  localparam int PAGE_BYTES = PAGE_MAIN + PAGE_SPARE;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int ROW_W      = 8 * ROW_BYTES;
  localparam int ADDR_CYC   = 1 + ROW_BYTES;
  localparam int PIB_W      = $clog2(PAGES_PER_BLK);
  localparam int SPARE_W    = $clog2(PAGE_SPARE);
  localparam int PG_W       = $clog2(STORED_PAGES);
  localparam int LAST_COL   = PAGE_BYTES - 1;
  localparam int HALF_COL   = PAGE_MAIN / 2;

  rd_state_e            state_q, state_d;
  logic [COL_W-1:0]     col_q, col_d;
  logic [ROW_W-1:0]     row_q, row_d;
  logic                 spare_q, spare_d;
  logic                 upper_q, upper_d;
  logic                 eob_q, eob_d;
  logic [7:0]           dout_q, dout_d;
  logic                 vld_q, vld_d;
  logic                 load_start;
  logic                 load_busy, load_expire;
  op_dec_t              dec;
  logic [ADDR_CYC*8-1:0] abytes;
  logic                 addr_done;
  logic [7:0]           rom_q;
  logic [7:0]           colbyte;

  nand_cmd_decode u_dec (
    .code_i (bus_in),
    .dec_o  (dec)
  );

  nand_addr_collect #(.ADDR_CYC(ADDR_CYC)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .restart (cmd_we),
    .arm     (state_q == ST_ADDR && !cmd_we),
    .we      (addr_we),
    .din     (bus_in),
    .bytes_o (abytes),
    .done    (addr_done)
  );

  nand_load_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (load_start),
    .abort  (cmd_we),
    .busy   (load_busy),
    .expire (load_expire)
  );

  // Addressed with the next pointer so rom_q always matches the current one
  nand_page_rom #(.STORED_PAGES(STORED_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_rom (
    .clk    (clk),
    .page_i (row_d[PG_W-1:0]),
    .col_i  (col_d),
    .q_o    (rom_q)
  );

  assign colbyte = abytes[7:0];

  always_comb begin
    state_d    = state_q;
    col_d      = col_q;
    row_d      = row_q;
    spare_d    = spare_q;
    upper_d    = upper_q;
    eob_d      = eob_q;
    dout_d     = '0;
    vld_d      = 1'b0;
    load_start = 1'b0;
    if (cmd_we) begin
      eob_d = 1'b0;
      if (dec.main) begin
        spare_d = 1'b0;
        upper_d = 1'b0;
        state_d = ST_ADDR;
      end else if (dec.upper) begin
        upper_d = 1'b1;
        state_d = ST_ADDR;
      end else if (dec.spare) begin
        spare_d = 1'b1;
        state_d = ST_ADDR;
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (addr_done) begin
            row_d = abytes[ADDR_CYC*8-1:8];
            if (spare_q)
              col_d = COL_W'(PAGE_MAIN) + COL_W'(colbyte[SPARE_W-1:0]);
            else if (upper_q)
              col_d = COL_W'(HALF_COL) + COL_W'(colbyte);
            else
              col_d = COL_W'(colbyte);
            state_d    = ST_LOAD;
            load_start = 1'b1;
          end
        end
        ST_LOAD: begin
          if (load_expire) state_d = ST_STREAM;
        end
        ST_STREAM: begin
          if (rd_stb) begin
            vld_d  = 1'b1;
            dout_d = rom_q;
            if (col_q == COL_W'(LAST_COL)) begin
              if (row_q[PIB_W-1:0] == {PIB_W{1'b1}}) begin
                state_d = ST_END;
              end else begin
                row_d      = row_q + ROW_W'(1);
                col_d      = spare_q ? COL_W'(PAGE_MAIN) : '0;
                state_d    = ST_LOAD;
                load_start = 1'b1;
              end
            end else begin
              col_d = col_q + COL_W'(1);
            end
          end
        end
        ST_END: begin
          if (rd_stb) begin
            vld_d  = 1'b1;
            dout_d = IDLE_BYTE;
            eob_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      spare_q <= 1'b0;
      upper_q <= 1'b0;
      eob_q   <= 1'b0;
      dout_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      row_q   <= row_d;
      spare_q <= spare_d;
      upper_q <= upper_d;
      eob_q   <= eob_d;
      dout_q  <= dout_d;
      vld_q   <= vld_d;
    end
  end

  assign dout         = dout_q;
  assign dout_vld     = vld_q;
  assign busy         = load_busy;
  assign end_of_block = eob_q;

  // R2
  vld_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> $past(rd_stb));

  // R7
  busy_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !dout_vld);

  // R10
  eob_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    end_of_block && !cmd_we |=> end_of_block);

  // R11
  cmd_clears_eob_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> !end_of_block);

  // R5
  spare_window_chk: assert property (@(posedge clk) disable iff (rst)
    spare_q && state_q == ST_STREAM |-> col_q >= COL_W'(PAGE_MAIN));

  // R8
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    col_q <= COL_W'(LAST_COL));

endmodule

// File: tb/nand_page_reader_bench.sv
module nand_page_reader_bench;

  localparam int BUSY = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic       addr_we = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic       rd_stb = 1'b0;
  logic [7:0] dout;
  logic       dout_vld;
  logic       busy;
  logic       end_of_block;

  always #2 clk = ~clk;

  nand_page_reader #(.BUSY_CYCLES(BUSY)) u_nand_page_reader (
    .clk          (clk),
    .rst          (rst),
    .cmd_we       (cmd_we),
    .addr_we      (addr_we),
    .bus_in       (bus_in),
    .rd_stb       (rd_stb),
    .dout         (dout),
    .dout_vld     (dout_vld),
    .busy         (busy),
    .end_of_block (end_of_block)
  );

  int    n_checks = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    finished = 0;
  int    cyc = 0;

  // Behavioural model: 0 idle, 1 address, 2 busy, 3 streaming, 4 block end
  int m_st, m_spare, m_upper, m_acnt, m_col, m_row, m_bcnt, m_dout, m_vld, m_eob;
  int m_ab [3];

  function automatic int pat(int row, int col);
    return ((col % 256) ^ ((row % 4) * 32) ^ (col / 256)) & 255;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_spare = 0; m_upper = 0; m_acnt = 0;
      m_col = 0; m_row = 0; m_bcnt = 0; m_dout = 0; m_vld = 0; m_eob = 0;
    end else begin
      m_vld = 0;
      m_dout = 0;
      if (cmd_we) begin
        m_eob = 0;
        m_acnt = 0;
        if (bus_in == 8'h00) begin m_spare = 0; m_upper = 0; m_st = 1; end
        else if (bus_in == 8'h01) begin m_upper = 1; m_st = 1; end
        else if (bus_in == 8'h50) begin m_spare = 1; m_st = 1; end
        else m_st = 0;
      end else if (m_st == 1) begin
        if (addr_we) begin
          m_ab[m_acnt] = int'(bus_in);
          m_acnt++;
          if (m_acnt == 3) begin
            m_acnt = 0;
            m_row = m_ab[1] + 256 * m_ab[2];
            if (m_spare != 0) m_col = 512 + (m_ab[0] % 16);
            else if (m_upper != 0) m_col = 256 + m_ab[0];
            else m_col = m_ab[0];
            m_st = 2;
            m_bcnt = BUSY;
          end
        end
      end else if (m_st == 2) begin
        m_bcnt--;
        if (m_bcnt == 0) m_st = 3;
      end else if (m_st == 3) begin
        if (rd_stb) begin
          m_vld = 1;
          m_dout = pat(m_row, m_col);
          if (m_col == 527) begin
            if (m_row % 16 == 15) m_st = 4;
            else begin
              m_row = (m_row + 1) % 65536;
              m_col = (m_spare != 0) ? 512 : 0;
              m_st = 2;
              m_bcnt = BUSY;
            end
          end else m_col++;
        end
      end else if (m_st == 4) begin
        if (rd_stb) begin m_vld = 1; m_dout = 255; m_eob = 1; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(dout_vld == (m_vld != 0), cur_req, "dout_vld", int'(dout_vld), m_vld);
      check(int'(dout) == m_dout, cur_req, "dout", int'(dout), m_dout);
      check(busy == (m_st == 2), "R7", "busy", int'(busy), int'(m_st == 2));
      check(end_of_block == (m_eob != 0), "R10", "end_of_block",
            int'(end_of_block), m_eob);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  task automatic step(input logic c, input logic a, input logic [7:0] b, input logic r);
    cmd_we = c; addr_we = a; bus_in = b; rd_stb = r;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    step(1'b1, 1'b0, b, 1'b0);
  endtask

  task automatic adr(input logic [7:0] b);
    step(1'b0, 1'b1, b, 1'b0);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(dout_vld == 1'b0, "R1", "dout_vld after reset", int'(dout_vld), 0);
    check(end_of_block == 1'b0, "R1", "end_of_block after reset", int'(end_of_block), 0);
    check(dout == 8'h00, "R1", "dout after reset", int'(dout), 0);

    // R3 R6 R2 R8: main read from column 5 of block 2 page 14, strobe during address ignored
    cur_req = "R3/R6/R2/R8";
    cmd(8'h00);
    adr(8'h05);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    adr(8'h2E);
    adr(8'h00);
    read_n(1062);
    // R10: strobes after block end
    cur_req = "R10";
    read_n(5);

    // R11 R4: new command clears flag, upper-half start
    cur_req = "R11/R4/R8";
    cmd(8'h01);
    adr(8'h03);
    adr(8'h07);
    adr(8'h00);
    read_n(290);

    // R5 R9: spare mode, upper nibble ignored, rollover to 512
    cur_req = "R5/R9";
    cmd(8'h50);
    adr(8'hF7);
    adr(8'h14);
    adr(8'h00);
    read_n(50);

    // R5: spare persists through 01h
    cur_req = "R5";
    cmd(8'h01);
    adr(8'h22);
    adr(8'h01);
    adr(8'h00);
    read_n(24);

    // R5 R10: spare read of the last page in a block, high row byte used
    cur_req = "R5/R10/R6";
    cmd(8'h50);
    adr(8'h00);
    adr(8'h1F);
    adr(8'h03);
    read_n(30);

    // R3: 00h returns to main area
    cur_req = "R3/R2";
    cmd(8'h00);
    adr(8'h80);
    adr(8'h10);
    adr(8'h00);
    read_n(20);

    // R11 R6: unknown command aborts; idle address bytes and strobes ignored
    cur_req = "R11/R6";
    cmd(8'h70);
    read_n(5);
    adr(8'h12);
    adr(8'h34);
    adr(8'h00);
    read_n(12);

    // R12: command wins over a simultaneous address byte; command cancels busy
    cur_req = "R12";
    cmd(8'h00);
    adr(8'h01);
    step(1'b1, 1'b1, 8'h00, 1'b0);
    adr(8'h09);
    adr(8'h02);
    adr(8'h00);
    read_n(12);
    cmd(8'h00);
    adr(8'h04);
    adr(8'h05);
    adr(8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    cmd(8'h01);
    adr(8'h00);
    adr(8'h04);
    adr(8'h00);
    read_n(10);
    step(1'b1, 1'b0, 8'h00, 1'b1);
    read_n(4);
    adr(8'h10);
    adr(8'h00);
    adr(8'h00);
    read_n(10);

    step(1'b0, 1'b0, 8'h00, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule